// File: doc/BRIEF.md
# Two-Level Global-History Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken. It keeps a table of small 2-bit prediction entries. The table is addressed by the word-address bits of the fetch PC, concatenated with a short shift register of the outcomes of the most recently resolved branches. The history value picks one of several entry sets, and the PC bits pick an entry inside that set. A lookup is purely combinational: the front end presents a PC and reads a taken/not-taken answer in the same cycle.

Each entry pairs a direction bit with a flag that marks whether the entry's previous guess was wrong. A single misprediction only raises the flag. The direction turns around only when the same entry is wrong twice in a row. When the execute stage resolves a branch, it reports the PC and the real outcome on the update port. The entry used for that branch is rewritten, and the outcome is shifted into the history. Nothing else changes the state.

Top module: `gbhist_dir_pred`

## Requirements
- R1: After reset every entry holds direction not-taken with the wrong flag clear, and the history register is all zeros, so every lookup answers not-taken.
- R2: The entry address is {history, pc[IDX_W+1:2]}, with history in the upper bits. PC bits 1:0 and all PC bits above IDX_W+1 do not affect the chosen entry, and each distinct history value selects its own entry set.
- R3: An entry whose wrong flag is clear and whose direction matches the resolved outcome keeps its state.
- R4: An entry whose wrong flag is clear and whose direction differs from the outcome sets its wrong flag and keeps its direction.
- R5: An entry whose wrong flag is set and whose direction matches the outcome clears its wrong flag and keeps its direction.
- R6: An entry whose wrong flag is set and whose direction differs from the outcome takes the outcome as its new direction and clears its wrong flag.
- R7: Each valid update shifts the outcome (taken = 1) into bit 0 of the history, and the older bits move one place up. The prediction therefore depends on the last two resolved outcomes.
- R8: While up_valid is low, neither the table nor the history changes, whatever up_pc and up_taken carry.
- R9: A lookup in the same cycle as an update to the same entry returns the value the entry held before that update. The new value is seen from the following cycle.
- R10: lk_taken is the direction bit of the addressed entry. It follows lk_pc and the current history within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A vector walk alternates two aliasing PCs and a neighbour. It mixes taken, not-taken and idle updates while a reference model follows each entry and the history. This separates faults in the four entry transitions from faults in indexing. Directed sequences return the history to a known context before each step. They then show separately that one miss does not flip a direction, that two misses do, and that a correct outcome clears the wrong flag in each state. Further sequences train one outcome context and probe others, which shows that the history really selects the set. Idle cycles with a taken outcome and then a not-taken outcome expose any history or table write without up_valid.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

  // One prediction entry: guessed direction plus "last guess was wrong" flag.
  typedef struct packed {
    logic dir;
    logic miss;
  } gbp_entry_t;

  localparam gbp_entry_t GBP_ENTRY_INIT = '{dir: 1'b0, miss: 1'b0};

  // Entry transition for one resolved outcome.
  function automatic gbp_entry_t gbp_step(gbp_entry_t cur, logic outcome);
    gbp_entry_t nxt;
    nxt = cur;
    if (cur.dir == outcome) begin
      nxt.miss = 1'b0;
    end else if (!cur.miss) begin
      nxt.miss = 1'b1;
    end else begin
      nxt.dir  = outcome;
      nxt.miss = 1'b0;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/gbp_hist.sv
module gbp_hist #(
  parameter int H_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           bit_in,
  output logic [H_W-1:0] hist_o
);

  logic [H_W-1:0] hist_q;
  logic [H_W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) begin
      hist_d = {hist_q[H_W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_d;
    end
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/gbp_index.sv
module gbp_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int H_W   = 2,
  localparam int ADDR_W = IDX_W + H_W
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [H_W-1:0]    hist,
  output logic [ADDR_W-1:0] addr
);

  // Word-aligned PC: the two lowest bits carry no information.
  assign addr = {hist, pc[IDX_W+1:2]};

endmodule

// File: rtl/gbp_table.sv
module gbp_table
  import gbp_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output gbp_entry_t        rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output gbp_entry_t        rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  gbp_entry_t        wr_data
);

  gbp_entry_t mem_q [DEPTH];

  assign rd_a_data = mem_q[rd_a_addr];
  assign rd_b_data = mem_q[rd_b_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= GBP_ENTRY_INIT;
      end
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

endmodule

// File: rtl/gbhist_dir_pred.sv
module gbhist_dir_pred
  import gbp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int H_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);

  localparam int ADDR_W = IDX_W + H_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [H_W-1:0]    ghist;
  logic [ADDR_W-1:0] lk_idx;
  logic [ADDR_W-1:0] up_idx;
  gbp_entry_t        lk_state;
  gbp_entry_t        up_state;
  gbp_entry_t        up_next;

  gbp_hist #(.H_W(H_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (up_valid),
    .bit_in   (up_taken),
    .hist_o   (ghist)
  );

  gbp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .H_W(H_W)) u_lk_index (
    .pc   (lk_pc),
    .hist (ghist),
    .addr (lk_idx)
  );

  gbp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .H_W(H_W)) u_up_index (
    .pc   (up_pc),
    .hist (ghist),
    .addr (up_idx)
  );

  always_comb begin
    up_next = gbp_step(up_state, up_taken);
  end

  gbp_table #(.ADDR_W(ADDR_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_a_addr (lk_idx),
    .rd_a_data (lk_state),
    .rd_b_addr (up_idx),
    .rd_b_data (up_state),
    .wr_en     (up_valid),
    .wr_addr   (up_idx),
    .wr_data   (up_next)
  );

  assign lk_taken = lk_state.dir;

endmodule

// File: rtl/gbp_checker.sv
module gbp_checker #(
  parameter int ADDR_W = 12,
  parameter int H_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_taken,
  input logic [ADDR_W-1:0] up_idx,
  input logic [1:0]        up_state,
  input logic [ADDR_W-1:0] lk_idx,
  input logic [1:0]        lk_state,
  input logic [H_W-1:0]    hist
);

  // state bit 1 = direction, bit 0 = wrong flag

  a_r1_hist_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> hist == '0);

  a_r3_right_hit_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_state[0] && up_state[1] == up_taken) |=>
      (lk_idx != $past(up_idx)) || (lk_state == $past(up_state)));

  a_r4_first_miss_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_state[0] && up_state[1] != up_taken) |=>
      (lk_idx != $past(up_idx)) || (lk_state == {$past(up_state[1]), 1'b1}));

  a_r5_wrong_hit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_state[0] && up_state[1] == up_taken) |=>
      (lk_idx != $past(up_idx)) || (lk_state == {$past(up_state[1]), 1'b0}));

  a_r6_second_miss_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_state[0] && up_state[1] != up_taken) |=>
      (lk_idx != $past(up_idx)) || (lk_state == {~$past(up_state[1]), 1'b0}));

  a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> hist == {$past(hist[H_W-2:0]), $past(up_taken)});

  a_r8_idle_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(hist));

endmodule

bind gbhist_dir_pred gbp_checker #(.ADDR_W(ADDR_W), .H_W(H_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .up_valid (up_valid),
  .up_taken (up_taken),
  .up_idx   (up_idx),
  .up_state (up_state),
  .lk_idx   (lk_idx),
  .lk_state (lk_state),
  .hist     (ghist)
);

// File: tb/tb_gbhist_dir_pred.sv
module tb_gbhist_dir_pred;

  localparam int PC_W   = 32;
  localparam int IDX_W  = 10;
  localparam int H_W    = 2;
  localparam int ADDR_W = IDX_W + H_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic            clk;
  logic            rst_n;
  logic [PC_W-1:0] lk_pc;
  logic            lk_taken;
  logic            up_valid;
  logic [PC_W-1:0] up_pc;
  logic            up_taken;

  gbhist_dir_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .H_W(H_W)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_pc    (lk_pc),
    .lk_taken (lk_taken),
    .up_valid (up_valid),
    .up_pc    (up_pc),
    .up_taken (up_taken)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  // Reference model built from the requirements.
  logic [1:0]     m_tbl [DEPTH];
  logic [H_W-1:0] m_hist;

  function automatic int m_idx(logic [PC_W-1:0] pc, logic [H_W-1:0] h);
    logic [ADDR_W-1:0] a;
    a = {h, pc[IDX_W+1:2]};
    return int'(a);
  endfunction

  function automatic logic [1:0] m_next(logic [1:0] s, logic t);
    if (!s[0] && s[1] == t) return s;               // R3
    if (!s[0] && s[1] != t) return {s[1], 1'b1};    // R4
    if (s[0] && s[1] == t)  return {s[1], 1'b0};    // R5
    return {t, 1'b0};                               // R6
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    up_valid = 1'b0;
    up_taken = 1'b0;
    up_pc    = '0;
    lk_pc    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) m_tbl[i] = 2'b00;
    m_hist = '0;
  endtask

  // Called just after a falling edge; the write happens on the next rising edge.
  task automatic upd(input logic [PC_W-1:0] pc, input logic t);
    up_valid = 1'b1;
    up_pc    = pc;
    up_taken = t;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input logic exp, input string tag);
    lk_pc = pc;
    #1;
    chk(lk_taken, exp, tag);
  endtask

  typedef struct packed {
    logic            v;
    logic [PC_W-1:0] upc;
    logic            t;
    logic [PC_W-1:0] lpc;
  } vec_t;

  localparam logic [PC_W-1:0] PA = 32'h0000_0040;
  localparam logic [PC_W-1:0] PB = 32'h0000_0080;
  localparam logic [PC_W-1:0] PC = 32'h0000_1040; // aliases PA in the index bits
  localparam int NV = 20;

  localparam vec_t VECS [NV] = '{
    '{1'b1, PA, 1'b1, PA}, '{1'b1, PA, 1'b1, PA}, '{1'b1, PB, 1'b0, PA},
    '{1'b1, PA, 1'b1, PA}, '{1'b1, PA, 1'b1, PC}, '{1'b0, PA, 1'b0, PA},
    '{1'b0, PB, 1'b1, PA}, '{1'b1, PA, 1'b0, PA}, '{1'b1, PA, 1'b0, PA},
    '{1'b1, PB, 1'b1, PB}, '{1'b1, PB, 1'b1, PB}, '{1'b1, PA, 1'b1, PB},
    '{1'b1, PB, 1'b0, PA}, '{1'b1, PA, 1'b0, PB}, '{1'b1, PC, 1'b1, PC},
    '{1'b1, PC, 1'b1, PA}, '{1'b0, PC, 1'b0, PC}, '{1'b1, PB, 1'b1, PA},
    '{1'b1, PA, 1'b1, PA}, '{1'b1, PA, 1'b1, PA}
  };

  localparam logic [PC_W-1:0] P = 32'h0000_0100;
  localparam logic [PC_W-1:0] Q = 32'h0000_0204;

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    do_reset();

    // R1: fresh table predicts not-taken everywhere
    look(P, 1'b0, "R1 reset lookup P");
    look(Q, 1'b0, "R1 reset lookup Q");
    look(32'hFFFF_FFFC, 1'b0, "R1 reset lookup top address");

    // Table walk against the reference model (R3,R4,R5,R6,R7,R8,R9,R10)
    for (int i = 0; i < NV; i++) begin
      up_valid = VECS[i].v;
      up_pc    = VECS[i].upc;
      up_taken = VECS[i].t;
      lk_pc    = VECS[i].lpc;
      #1;
      chk(lk_taken, m_tbl[m_idx(VECS[i].lpc, m_hist)][1],
          $sformatf("walk step %0d (R3,R4,R5,R6,R7,R8,R9,R10)", i));
      if (VECS[i].v) begin
        m_tbl[m_idx(VECS[i].upc, m_hist)] = m_next(m_tbl[m_idx(VECS[i].upc, m_hist)], VECS[i].t);
        m_hist = {m_hist[H_W-2:0], VECS[i].t};
      end
      @(negedge clk);
    end
    up_valid = 1'b0;

    // R1: reset wipes trained state
    do_reset();
    look(PA, 1'b0, "R1 after retrain reset");

    // R9: same-cycle lookup sees the old entry (history 00)
    up_valid = 1'b1; up_pc = P; up_taken = 1'b1; lk_pc = P;
    #1;
    chk(lk_taken, 1'b0, "R9 same-cycle lookup");
    @(negedge clk);
    up_valid = 1'b0;
    // history now 01
    upd(Q, 1'b0); upd(Q, 1'b0);            // history 00
    upd(P, 1'b1);                          // second miss at (00,P): R6 flip, history 01
    look(P, 1'b0, "R2 other history set untouched");
    upd(Q, 1'b0); upd(Q, 1'b0);            // history 00
    look(P, 1'b1, "R6 two misses flip direction");
    look(P | 32'h3, 1'b1, "R2 low PC bits ignored");
    look(P + (32'h1 << (IDX_W + 2)), 1'b1, "R2 upper PC bits ignored");

    upd(P, 1'b0);                          // first miss, history 00
    look(P, 1'b1, "R4 single miss keeps direction");
    upd(P, 1'b1);                          // wrong + correct -> right, history 01
    upd(Q, 1'b0); upd(Q, 1'b0);            // history 00
    upd(P, 1'b0);                          // one miss again, history 00
    look(P, 1'b1, "R5 correct outcome cleared wrong flag");

    // R8: idle cycles with outcomes that would show up if taken in
    up_valid = 1'b0; up_pc = P; up_taken = 1'b1;
    @(negedge clk);
    up_taken = 1'b0;
    @(negedge clk);
    look(P, 1'b1, "R8 idle update left history and table");

    upd(P, 1'b1);                          // wrong + correct -> right-taken, history 01
    upd(Q, 1'b0); upd(Q, 1'b0);            // history 00
    upd(P, 1'b1);                          // R3 right + correct, history 01
    upd(Q, 1'b0); upd(Q, 1'b0);            // history 00
    upd(P, 1'b0);                          // one miss, history 00
    look(P, 1'b1, "R3 right state kept on correct outcome");

    // R7: train context "taken then not-taken", probe other contexts
    do_reset();
    upd(Q, 1'b1); upd(Q, 1'b0);
    upd(P, 1'b1);
    upd(Q, 1'b1); upd(Q, 1'b0);
    upd(P, 1'b1);
    upd(Q, 1'b1); upd(Q, 1'b0);
    look(P, 1'b1, "R7 trained outcome context");
    upd(Q, 1'b0); upd(Q, 1'b1);
    look(P, 1'b0, "R7 reversed outcome context");
    upd(Q, 1'b0); upd(Q, 1'b0);
    look(P, 1'b0, "R7 not-taken context");
    upd(Q, 1'b1); upd(Q, 1'b0);
    look(P, 1'b1, "R7 context restored");
    look(Q, 1'b0, "R10 lookup follows PC in same cycle");

    finish_run();
  end

endmodule